// File: doc/BRIEF.md
# Lifetime Usage Statistics Counters

This block holds the lifetime usage figures of a storage controller's health log. It counts data read and data written, host read and write commands, minutes of controller busy time, power cycles, powered hours and unsafe shutdowns. All of these are 64-bit counters. The counters are driven by completion pulses that carry block counts, a flag that says an I/O command is outstanding, a low-power flag, a one-second tick, and power-up and shutdown-notice events.

Data is counted in units of 512 bytes. A transfer with a larger logical block is first scaled to 512-byte units. The reported data values are in thousands of units, and any partial thousand rounds up. To do this, each data counter keeps an internal remainder from 0 to 999, and the reported value is one higher than the whole-thousand count while that remainder is non-zero.

Starting values come from non-volatile storage through a load port. A load selects one counter, writes its value and clears that counter's remainder. Every counter saturates at its maximum value and never wraps. Every output changes on the clock edge that samples its cause.

Top module: `lifetime_stats`

## Requirements
- R1: Each data counter reports ceil(total 512-byte units / 1000). Starting from zero, 1 unit reads as 1, 1000 units read as 1 and 1001 units read as 2. The output updates one cycle after the completion pulse.
- R2: The transferred amount is blocks × 2^blkShift units. blkShift = 0 means 512-byte blocks and blkShift = 3 means 4096-byte blocks.
- R3: A write completion with wrUncorr high leaves the data-written value unchanged. It still counts as one host write command.
- R4: Each rdDone or wrDone pulse adds exactly one to the matching host command counter, whatever its block count.
- R5: Busy minutes increase by one for every SEC_PER_MIN one-second ticks (default 60) sampled while cmdPending is high. Ticks sampled while cmdPending is low are not counted and do not reset the partial minute.
- R6: Power-on hours increase by one for every SEC_PER_HOUR ticks (default 3600) sampled while lowPower is low. Ticks sampled during low power do not count.
- R7: Every powerUp pulse adds one to the power-cycle count. A powerUp that follows an earlier powerUp with no shutdownNotify in between also adds one to the unsafe-shutdown count. The first powerUp after reset never counts as unsafe.
- R8: All counters saturate at 2^64−1 and never wrap.
- R9: loadEn writes loadData into the counter chosen by loadSel and clears that counter's remainder. The loadSel codes are:
  - 0: data read
  - 1: data written
  - 2: read commands
  - 3: write commands
  - 4: busy minutes
  - 5: power cycles
  - 6: power-on hours
  - 7: unsafe shutdowns

  The loaded value appears one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, clears all state |
| rdDone | input | 1 | Pulse: a host read has completed |
| rdBlocks | input | 16 | Logical blocks transferred by that read |
| wrDone | input | 1 | Pulse: a host write has completed |
| wrUncorr | input | 1 | The completing write is a write-uncorrectable command |
| wrBlocks | input | 16 | Logical blocks transferred by that write |
| blkShift | input | 2 | log2 of the logical block size in 512-byte units |
| cmdPending | input | 1 | At least one I/O command is submitted and not yet completed |
| lowPower | input | 1 | Controller is in a low-power state |
| secTick | input | 1 | One-cycle pulse once per second |
| powerUp | input | 1 | Pulse at each power-up |
| shutdownNotify | input | 1 | Pulse: the host gave notice of a shutdown |
| loadEn | input | 1 | Load a starting value |
| loadSel | input | 3 | Counter to load (codes in R9) |
| loadData | input | 64 | Value to load |
| dataUnitsRead | output | 64 | Data read, in thousands of 512-byte units, rounded up |
| dataUnitsWritten | output | 64 | Data written, in thousands of 512-byte units, rounded up |
| hostReadCmds | output | 64 | Host read command count |
| hostWriteCmds | output | 64 | Host write command count |
| busyMinutes | output | 64 | Controller busy time in minutes |
| powerCycles | output | 64 | Power-up count |
| powerOnHours | output | 64 | Hours powered and not in low power |
| unsafeShutdowns | output | 64 | Power losses without a prior shutdown notice |

## Verification
A wrong remainder in a data counter shows up at the port on the cycle after the pulse that crosses a thousand boundary, or when the remainder first leaves zero. For that reason the bench places transfers exactly on 1, 1000 and 1001 units.

The seconds prescalers are hidden state. An off-by-one in either of them is seen only on the tick that should complete a minute or an hour, so the bench reads the counter one tick before and on that tick.

The bench opens a session and then powers up again without notice. A session flag that is lost or stuck then shows at the next powerUp, as a wrong unsafe-shutdown count.

// File: rtl/lifetime_stats_pkg.sv
package lifetime_stats_pkg;
  localparam int NUM_CNT  = 8;
  localparam int NUM_BUMP = 6;
  // counter positions, equal to the loadSel codes
  localparam int IDX_DRD  = 0;
  localparam int IDX_DWR  = 1;
  localparam int IDX_RCMD = 2;
  localparam int IDX_WCMD = 3;
  localparam int IDX_BUSY = 4;
  localparam int IDX_PCYC = 5;
  localparam int IDX_POH  = 6;
  localparam int IDX_UNS  = 7;
  // single-step counters sit after the two data counters
  localparam int BUMP_BASE = 2;

  typedef struct packed {
    logic                rdData;
    logic                wrData;
    logic [NUM_BUMP-1:0] bump;   // bit i steps counter BUMP_BASE+i
  } strobes_t;
endpackage

// File: rtl/lifetime_stats_ctrl.sv
module lifetime_stats_ctrl
  import lifetime_stats_pkg::*;
#(
  parameter int BLK_W        = 16,
  parameter int SHIFT_W      = 2,
  parameter int UNIT_W       = BLK_W + (1 << SHIFT_W) - 1,
  parameter int SEC_PER_MIN  = 60,
  parameter int SEC_PER_HOUR = 3600
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdDone,
  input  logic [BLK_W-1:0]  rdBlocks,
  input  logic              wrDone,
  input  logic              wrUncorr,
  input  logic [BLK_W-1:0]  wrBlocks,
  input  logic [SHIFT_W-1:0] blkShift,
  input  logic              cmdPending,
  input  logic              lowPower,
  input  logic              secTick,
  input  logic              powerUp,
  input  logic              shutdownNotify,
  output strobes_t          stb,
  output logic [UNIT_W-1:0] rdUnits,
  output logic [UNIT_W-1:0] wrUnits
);
  localparam int MIN_W = $clog2(SEC_PER_MIN);
  localparam int HR_W  = $clog2(SEC_PER_HOUR);

  logic [MIN_W-1:0] busySec;
  logic [HR_W-1:0]  onSec;
  logic             sessionOpen;
  logic             busyTick, onTick, minuteDone, hourDone;

  assign busyTick   = secTick && cmdPending;
  assign onTick     = secTick && !lowPower;
  assign minuteDone = busyTick && (busySec == MIN_W'(SEC_PER_MIN - 1));
  assign hourDone   = onTick && (onSec == HR_W'(SEC_PER_HOUR - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busySec     <= '0;
      onSec       <= '0;
      sessionOpen <= 1'b0;
    end else begin
      if (busyTick) busySec <= minuteDone ? '0 : busySec + 1'b1;
      if (onTick)   onSec   <= hourDone ? '0 : onSec + 1'b1;
      if (powerUp)             sessionOpen <= 1'b1;
      else if (shutdownNotify) sessionOpen <= 1'b0;
    end
  end

  assign rdUnits = UNIT_W'(rdBlocks) << blkShift;
  assign wrUnits = UNIT_W'(wrBlocks) << blkShift;

  always_comb begin
    stb.rdData = rdDone;
    stb.wrData = wrDone && !wrUncorr;
    stb.bump[IDX_RCMD-BUMP_BASE] = rdDone;
    stb.bump[IDX_WCMD-BUMP_BASE] = wrDone;
    stb.bump[IDX_BUSY-BUMP_BASE] = minuteDone;
    stb.bump[IDX_PCYC-BUMP_BASE] = powerUp;
    stb.bump[IDX_POH-BUMP_BASE]  = hourDone;
    stb.bump[IDX_UNS-BUMP_BASE]  = powerUp && sessionOpen;
  end
endmodule

// File: rtl/lifetime_stats_dp.sv
module lifetime_stats_dp
  import lifetime_stats_pkg::*;
#(
  parameter int CNT_W     = 64,
  parameter int UNIT_W    = 19,
  parameter int SUB_LIMIT = 1000
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  strobes_t                         stb,
  input  logic [UNIT_W-1:0]                rdUnits,
  input  logic [UNIT_W-1:0]                wrUnits,
  input  logic                             loadEn,
  input  logic [2:0]                       loadSel,
  input  logic [CNT_W-1:0]                 loadData,
  output logic [NUM_CNT-1:0][CNT_W-1:0]    vals
);
  localparam int SUB_W = $clog2(SUB_LIMIT);
  localparam int SUM_W = UNIT_W + 1;
  localparam logic [CNT_W-1:0] MAXV = '1;

  for (genvar d = 0; d < 2; d++) begin : g_data
    logic [CNT_W-1:0] base;
    logic [SUB_W-1:0] sub;
    logic [SUM_W-1:0] sum;
    logic [CNT_W:0]   wide;
    logic             add;
    logic [UNIT_W-1:0] units;
    logic             ld;

    assign add   = (d == 0) ? stb.rdData : stb.wrData;
    assign units = (d == 0) ? rdUnits : wrUnits;
    assign ld    = loadEn && (loadSel == 3'(d));

    always_comb begin
      sum  = SUM_W'(sub) + SUM_W'(units);
      wide = {1'b0, base} + (CNT_W+1)'(sum / SUB_LIMIT);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        base <= '0;
        sub  <= '0;
      end else if (ld) begin
        base <= loadData;
        sub  <= '0;
      end else if (add) begin
        base <= wide[CNT_W] ? MAXV : wide[CNT_W-1:0];
        sub  <= SUB_W'(sum % SUB_LIMIT);
      end
    end

    assign vals[d] = (base == MAXV) ? MAXV : base + CNT_W'(sub != '0);
  end

  for (genvar b = 0; b < NUM_BUMP; b++) begin : g_step
    logic [CNT_W-1:0] cnt;
    logic             ld;
    assign ld = loadEn && (loadSel == 3'(b + BUMP_BASE));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          cnt <= '0;
      else if (ld)                        cnt <= loadData;
      else if (stb.bump[b] && cnt != MAXV) cnt <= cnt + 1'b1;
    end

    assign vals[b + BUMP_BASE] = cnt;
  end
endmodule

// File: rtl/lifetime_stats.sv
module lifetime_stats
  import lifetime_stats_pkg::*;
#(
  parameter int CNT_W        = 64,
  parameter int BLK_W        = 16,
  parameter int SHIFT_W      = 2,
  parameter int SUB_LIMIT    = 1000,
  parameter int SEC_PER_MIN  = 60,
  parameter int SEC_PER_HOUR = 3600
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rdDone,
  input  logic [BLK_W-1:0]   rdBlocks,
  input  logic               wrDone,
  input  logic               wrUncorr,
  input  logic [BLK_W-1:0]   wrBlocks,
  input  logic [SHIFT_W-1:0] blkShift,
  input  logic               cmdPending,
  input  logic               lowPower,
  input  logic               secTick,
  input  logic               powerUp,
  input  logic               shutdownNotify,
  input  logic               loadEn,
  input  logic [2:0]         loadSel,
  input  logic [CNT_W-1:0]   loadData,
  output logic [CNT_W-1:0]   dataUnitsRead,
  output logic [CNT_W-1:0]   dataUnitsWritten,
  output logic [CNT_W-1:0]   hostReadCmds,
  output logic [CNT_W-1:0]   hostWriteCmds,
  output logic [CNT_W-1:0]   busyMinutes,
  output logic [CNT_W-1:0]   powerCycles,
  output logic [CNT_W-1:0]   powerOnHours,
  output logic [CNT_W-1:0]   unsafeShutdowns
);
  localparam int UNIT_W = BLK_W + (1 << SHIFT_W) - 1;

  strobes_t                          stb;
  logic [UNIT_W-1:0]                 rdUnits, wrUnits;
  logic [NUM_CNT-1:0][CNT_W-1:0]     vals;

  lifetime_stats_ctrl #(
    .BLK_W(BLK_W), .SHIFT_W(SHIFT_W), .UNIT_W(UNIT_W),
    .SEC_PER_MIN(SEC_PER_MIN), .SEC_PER_HOUR(SEC_PER_HOUR)
  ) u_ctrl (
    .clk, .rstN, .rdDone, .rdBlocks, .wrDone, .wrUncorr, .wrBlocks,
    .blkShift, .cmdPending, .lowPower, .secTick, .powerUp, .shutdownNotify,
    .stb, .rdUnits, .wrUnits
  );

  lifetime_stats_dp #(
    .CNT_W(CNT_W), .UNIT_W(UNIT_W), .SUB_LIMIT(SUB_LIMIT)
  ) u_dp (
    .clk, .rstN, .stb, .rdUnits, .wrUnits, .loadEn, .loadSel, .loadData, .vals
  );

  assign dataUnitsRead    = vals[IDX_DRD];
  assign dataUnitsWritten = vals[IDX_DWR];
  assign hostReadCmds     = vals[IDX_RCMD];
  assign hostWriteCmds    = vals[IDX_WCMD];
  assign busyMinutes      = vals[IDX_BUSY];
  assign powerCycles      = vals[IDX_PCYC];
  assign powerOnHours     = vals[IDX_POH];
  assign unsafeShutdowns  = vals[IDX_UNS];
endmodule

// File: rtl/lifetime_stats_chk.sv
module lifetime_stats_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             rdDone,
  input logic             wrDone,
  input logic             wrUncorr,
  input logic             cmdPending,
  input logic             lowPower,
  input logic             powerUp,
  input logic             loadEn,
  input logic [CNT_W-1:0] dataUnitsRead,
  input logic [CNT_W-1:0] dataUnitsWritten,
  input logic [CNT_W-1:0] hostReadCmds,
  input logic [CNT_W-1:0] powerCycles,
  input logic [CNT_W-1:0] busyMinutes,
  input logic [CNT_W-1:0] powerOnHours,
  input logic [CNT_W-1:0] unsafeShutdowns
);
  // R8
  no_wrap_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadEn |=> dataUnitsRead >= $past(dataUnitsRead));
  // R8
  no_wrap_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadEn |=> hostReadCmds >= $past(hostReadCmds));
  // R3
  uncorr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrDone && wrUncorr && !loadEn) |=> $stable(dataUnitsWritten));
  // R4
  rd_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rdDone && !loadEn) |=> $stable(hostReadCmds));
  // R5
  busy_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdPending && !loadEn) |=> $stable(busyMinutes));
  // R6
  poh_lowpwr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lowPower && !loadEn) |=> $stable(powerOnHours));
  // R7
  pcyc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!powerUp && !loadEn) |=> $stable(powerCycles));
  // R7
  unsafe_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!powerUp && !loadEn) |=> $stable(unsafeShutdowns));
endmodule

bind lifetime_stats lifetime_stats_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .rdDone(rdDone), .wrDone(wrDone),
  .wrUncorr(wrUncorr), .cmdPending(cmdPending), .lowPower(lowPower),
  .powerUp(powerUp), .loadEn(loadEn), .dataUnitsRead(dataUnitsRead),
  .dataUnitsWritten(dataUnitsWritten), .hostReadCmds(hostReadCmds),
  .powerCycles(powerCycles), .busyMinutes(busyMinutes),
  .powerOnHours(powerOnHours), .unsafeShutdowns(unsafeShutdowns)
);

// File: tb/lifetime_stats_tb.sv
`timescale 1ns/1ps
module lifetime_stats_tb;
  localparam logic [63:0] MAXV = '1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdDone = 0, wrDone = 0, wrUncorr = 0;
  logic [15:0] rdBlocks = 0, wrBlocks = 0;
  logic [1:0]  blkShift = 0;
  logic        cmdPending = 0, lowPower = 0, secTick = 0;
  logic        powerUp = 0, shutdownNotify = 0;
  logic        loadEn = 0;
  logic [2:0]  loadSel = 0;
  logic [63:0] loadData = 0;
  logic [63:0] dataUnitsRead, dataUnitsWritten, hostReadCmds, hostWriteCmds;
  logic [63:0] busyMinutes, powerCycles, powerOnHours, unsafeShutdowns;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lifetime_stats u_dut (
    .clk, .rstN, .rdDone, .rdBlocks, .wrDone, .wrUncorr, .wrBlocks,
    .blkShift, .cmdPending, .lowPower, .secTick, .powerUp, .shutdownNotify,
    .loadEn, .loadSel, .loadData,
    .dataUnitsRead, .dataUnitsWritten, .hostReadCmds, .hostWriteCmds,
    .busyMinutes, .powerCycles, .powerOnHours, .unsafeShutdowns
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic doRead(input logic [15:0] blocks, input logic [1:0] sh);
    @(negedge clk); rdDone = 1; rdBlocks = blocks; blkShift = sh;
    @(negedge clk); rdDone = 0;
  endtask

  task automatic doWrite(input logic [15:0] blocks, input logic [1:0] sh, input logic unc);
    @(negedge clk); wrDone = 1; wrBlocks = blocks; blkShift = sh; wrUncorr = unc;
    @(negedge clk); wrDone = 0; wrUncorr = 0;
  endtask

  task automatic doLoad(input logic [2:0] sel, input logic [63:0] v);
    @(negedge clk); loadEn = 1; loadSel = sel; loadData = v;
    @(negedge clk); loadEn = 0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); secTick = 1;
    repeat (n) @(negedge clk);
    secTick = 0;
  endtask

  task automatic pulsePowerUp();
    @(negedge clk); powerUp = 1;
    @(negedge clk); powerUp = 0;
  endtask

  task automatic pulseNotify();
    @(negedge clk); shutdownNotify = 1;
    @(negedge clk); shutdownNotify = 0;
  endtask

  task automatic testReset();
    check("reset dataUnitsRead", dataUnitsRead, 0);
    check("reset dataUnitsWritten", dataUnitsWritten, 0);
    check("reset hostReadCmds", hostReadCmds, 0);
    check("reset powerCycles", powerCycles, 0);
    check("reset unsafeShutdowns", unsafeShutdowns, 0);
  endtask

  task automatic testRoundUp();
    doRead(1, 0);
    check("R1 one unit rounds up", dataUnitsRead, 1);
    doRead(999, 0);
    check("R1 exactly 1000 units", dataUnitsRead, 1);
    doRead(1, 0);
    check("R1 1001 units", dataUnitsRead, 2);
    check("R4 three reads counted", hostReadCmds, 3);
    doRead(1000, 0);
    check("R4 large read counts once", hostReadCmds, 4);
  endtask

  task automatic testBlockSize();
    doWrite(125, 3, 0);
    check("R2 125 x 4096B = 1000 units", dataUnitsWritten, 1);
    doWrite(1, 3, 0);
    check("R2 one more 4096B block", dataUnitsWritten, 2);
    check("R4 write commands", hostWriteCmds, 2);
  endtask

  task automatic testUncorr();
    doWrite(5, 0, 1);
    check("R3 uncorrectable write leaves data", dataUnitsWritten, 2);
    check("R3 uncorrectable write is a command", hostWriteCmds, 3);
  endtask

  task automatic testBusy();
    @(negedge clk); lowPower = 1; cmdPending = 1;
    ticks(59);
    check("R5 59 busy seconds", busyMinutes, 0);
    @(negedge clk); cmdPending = 0;
    ticks(10);
    check("R5 idle ticks ignored", busyMinutes, 0);
    @(negedge clk); cmdPending = 1;
    ticks(1);
    check("R5 60th busy second", busyMinutes, 1);
    @(negedge clk); cmdPending = 0;
    check("R6 low-power ticks ignored", powerOnHours, 0);
    @(negedge clk); lowPower = 0;
  endtask

  task automatic testHours();
    ticks(3599);
    check("R6 3599 seconds", powerOnHours, 0);
    ticks(1);
    check("R6 3600 seconds", powerOnHours, 1);
  endtask

  task automatic testPower();
    pulsePowerUp();
    check("R7 first power-up cycles", powerCycles, 1);
    check("R7 first power-up not unsafe", unsafeShutdowns, 0);
    pulsePowerUp();
    check("R7 second power-up cycles", powerCycles, 2);
    check("R7 missing notice counted", unsafeShutdowns, 1);
    pulseNotify();
    pulsePowerUp();
    check("R7 notified power-up cycles", powerCycles, 3);
    check("R7 notified power-up safe", unsafeShutdowns, 1);
  endtask

  task automatic testSaturate();
    doLoad(3'd2, MAXV - 1);
    doRead(1, 0);
    doRead(1, 0);
    check("R8 read commands saturate", hostReadCmds, MAXV);
    doLoad(3'd0, MAXV - 1);
    check("R9 load clears remainder", dataUnitsRead, MAXV - 1);
    doRead(1, 0);
    check("R8 partial reaches max", dataUnitsRead, MAXV);
    doRead(1000, 0);
    check("R8 data read saturates", dataUnitsRead, MAXV);
  endtask

  task automatic testLoad();
    doLoad(3'd6, 64'd42);
    check("R9 load power-on hours", powerOnHours, 42);
    doLoad(3'd1, 64'd7);
    check("R9 load data written", dataUnitsWritten, 7);
    check("R9 load leaves others", hostWriteCmds, 3);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testRoundUp();
    testBlockSize();
    testUncorr();
    testBusy();
    testHours();
    testPower();
    testSaturate();
    testLoad();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule